// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter for a microcontroller-style peripheral set, accessed through an 8-bit register bus. It has three count sources. The first is an instruction-cycle tick pulse supplied by the surrounding chip (timer mode). The second is the external clock pin resynchronized to the system clock (synchronous counter mode). The third is the external pin's edges taken without resynchronization (asynchronous counter mode, modelled as counting on the raw detected edge). Every source passes through a divide-by-1/2/4/8 prescaler before it reaches the counter. A run bit gates counting.

When the counter wraps, it sets a sticky overflow flag that software clears. A one-cycle trigger pulse from a compare unit resets the count to zero. In wide-access mode, a shared high-byte buffer makes 16-bit reads and writes atomic over the byte bus. Reading the low byte snapshots the high byte. Writing the high byte only stages it, and the next low-byte write commits both bytes at once.

Top module: `prescaled_timer16`

## Requirements
- R1: While `rst` is high, the count, the overflow flag and `rd_data` are cleared to zero.
- R2: With `src_ext`=0 and `run_en`=1, each cycle with `cyc_tick`=1 is one prescaler input event; `ext_clk_in` is ignored.
- R3: `psc_sel` codes 0,1,2,3 select divide ratios 1,2,4,8: the count advances on every N-th prescaler input event counted since the prescaler was last cleared.
- R4: With `src_ext`=1 and `sync_ext`=1, each rising edge of `ext_clk_in` is one event and `cyc_tick` is ignored. The pin passes a two-flop synchronizer, so at ratio 1 the count advances at the third clock edge that samples the pin high. A pin held high counts only once.
- R5: With `src_ext`=1 and `sync_ext`=0, the edge is detected on the raw pin, so at ratio 1 the count advances at the first clock edge that samples the pin high.
- R6: With `run_en`=0, neither the count nor the prescaler state changes on input events.
- R7: An increment from 0xFFFF gives 0x0000 and sets `ovf_flag`. The flag then stays set until `ovf_clr` is pulsed. A set in the same cycle as `ovf_clr` wins.
- R8: `trig_clr` clears the count to zero and takes priority over an increment. A counter write in the same cycle takes priority over `trig_clr`.
- R9: With `wide_mode`=0, `wr_lo`/`wr_hi` write the count's low/high byte directly, and `rd_lo`/`rd_hi` return the live low/high byte.
- R10: With `wide_mode`=1, `rd_lo` returns the live low byte and copies the live high byte into the buffer. `rd_hi` returns the buffer.
- R11: With `wide_mode`=1, `wr_hi` loads only the buffer and leaves the count unchanged. `wr_lo` loads {buffer, `wr_data`} into the count in one cycle.
- R12: Any write that changes the count clears the prescaler's partial count.
- R13: `rd_data` is registered. It changes only at the clock edge that samples `rd_lo` or `rd_hi` high, and it holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | Instruction-cycle tick pulse (timer source) |
| ext_clk_in | input | 1 | External count pin |
| run_en | input | 1 | Counting enable |
| src_ext | input | 1 | Source select: 0 tick, 1 external pin |
| sync_ext | input | 1 | 1 resynchronize external pin, 0 raw edge |
| psc_sel | input | 2 | Prescale code (0..3 gives 1,2,4,8) |
| wide_mode | input | 1 | Buffered 16-bit access mode |
| trig_clr | input | 1 | Special-event clear pulse |
| wr_lo | input | 1 | Low byte write strobe |
| wr_hi | input | 1 | High byte write strobe |
| rd_lo | input | 1 | Low byte read strobe |
| rd_hi | input | 1 | High byte read strobe |
| wr_data | input | 8 | Write data |
| ovf_clr | input | 1 | Clear the overflow flag |
| rd_data | output | 8 | Registered read data |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench measures the external-pin latency cycle by cycle. It watches a continuously strobed low-byte read while a single edge arrives. A design that skipped the synchronizer, or used it in asynchronous mode, would show the count two cycles early or late. Randomized prescale runs start from a fresh write. A prescaler that was not cleared on a write, or one that divided by the wrong power of two, would give a count off by one or by a factor.

The wide-mode tests change the high byte between the low and high reads, and stage a high byte before an unrelated read. A design that read the live high byte, or committed the staged byte early, would return a torn value. Collisions between the trigger and a write, between a wrap and a flag clear, and a run bit dropped with the prescaler mid-count, catch wrong priorities.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  // Source of the byte returned on a read strobe.
  typedef enum logic [1:0] {
    RDSRC_LIVE_LO = 2'd0,
    RDSRC_LIVE_HI = 2'd1,
    RDSRC_BUF_HI  = 2'd2
  } rd_src_e;

  // Prescale codes; the code is the log2 of the divide ratio.
  typedef enum logic [1:0] {
    PSC_DIV1 = 2'd0,
    PSC_DIV2 = 2'd1,
    PSC_DIV4 = 2'd2,
    PSC_DIV8 = 2'd3
  } psc_code_e;

endpackage

// File: rtl/tmr16_event_src.sv
module tmr16_event_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_tick,
  input  logic ext_clk_in,
  input  logic src_ext,
  input  logic sync_ext,
  output logic evt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_prev_q;
  logic                   raw_prev_q;
  logic                   sync_rise;
  logic                   raw_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q      <= '0;
      sync_prev_q <= 1'b0;
      raw_prev_q  <= 1'b0;
    end else begin
      sync_q      <= {sync_q[SYNC_STAGES-2:0], ext_clk_in};
      sync_prev_q <= sync_q[SYNC_STAGES-1];
      raw_prev_q  <= ext_clk_in;
    end
  end

  assign sync_rise = sync_q[SYNC_STAGES-1] & ~sync_prev_q;
  assign raw_rise  = ext_clk_in & ~raw_prev_q;

  always_comb begin
    if (!src_ext)      evt = cyc_tick;
    else if (sync_ext) evt = sync_rise;
    else               evt = raw_rise;
  end

endmodule

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             evt_in,
  input  logic [PSC_W-1:0] sel,
  output logic             evt_out
);

  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (i < int'(sel)) mask[i] = 1'b1;
    end
  end

  assign evt_out = run & evt_in & ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else if (run && evt_in) div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  input  logic               trig_clr,
  input  logic               wide_mode,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic               rd_lo,
  input  logic               rd_hi,
  input  logic [BUS_W-1:0]   wr_data,
  input  logic               ovf_clr,
  output logic [2*BUS_W-1:0] count,
  output logic [BUS_W-1:0]   rd_data,
  output logic               ovf_flag,
  output logic               cnt_write
);

  localparam int CNT_W = 2 * BUS_W;

  logic [CNT_W-1:0] cnt_q;
  logic [BUS_W-1:0] hbuf_q;
  logic [BUS_W-1:0] rd_q;
  logic             ovf_q;
  logic             wrap;
  rd_src_e          rd_src;
  logic [BUS_W-1:0] rd_byte;

  assign cnt_write = wr_lo | (wr_hi & ~wide_mode);
  assign wrap      = inc & ~cnt_write & ~trig_clr & (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_lo) begin
      cnt_q <= wide_mode ? {hbuf_q, wr_data} : {cnt_q[CNT_W-1:BUS_W], wr_data};
    end else if (wr_hi && !wide_mode) begin
      cnt_q <= {wr_data, cnt_q[BUS_W-1:0]};
    end else if (trig_clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     hbuf_q <= '0;
    else if (wide_mode && wr_hi) hbuf_q <= wr_data;
    else if (wide_mode && rd_lo) hbuf_q <= cnt_q[CNT_W-1:BUS_W];
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf_q <= 1'b0;
    else if (wrap)    ovf_q <= 1'b1;
    else if (ovf_clr) ovf_q <= 1'b0;
  end

  always_comb begin
    if (rd_lo)          rd_src = RDSRC_LIVE_LO;
    else if (wide_mode) rd_src = RDSRC_BUF_HI;
    else                rd_src = RDSRC_LIVE_HI;
    case (rd_src)
      RDSRC_LIVE_LO: rd_byte = cnt_q[BUS_W-1:0];
      RDSRC_LIVE_HI: rd_byte = cnt_q[CNT_W-1:BUS_W];
      default:       rd_byte = hbuf_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                rd_q <= '0;
    else if (rd_lo || rd_hi) rd_q <= rd_byte;
  end

  assign count    = cnt_q;
  assign rd_data  = rd_q;
  assign ovf_flag = ovf_q;

endmodule

// File: rtl/prescaled_timer16.sv
module prescaled_timer16 #(
  parameter int BUS_W       = 8,
  parameter int PSC_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_tick,
  input  logic             ext_clk_in,
  input  logic             run_en,
  input  logic             src_ext,
  input  logic             sync_ext,
  input  logic [PSC_W-1:0] psc_sel,
  input  logic             wide_mode,
  input  logic             trig_clr,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             rd_lo,
  input  logic             rd_hi,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             ovf_clr,
  output logic [BUS_W-1:0] rd_data,
  output logic             ovf_flag
);

  localparam int CNT_W = 2 * BUS_W;

  logic             evt_raw;
  logic             evt_div;
  logic             cnt_write;
  logic [CNT_W-1:0] count_q;

  tmr16_event_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk        (clk),
    .rst        (rst),
    .cyc_tick   (cyc_tick),
    .ext_clk_in (ext_clk_in),
    .src_ext    (src_ext),
    .sync_ext   (sync_ext),
    .evt        (evt_raw)
  );

  tmr16_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .clr     (cnt_write),
    .run     (run_en),
    .evt_in  (evt_raw),
    .sel     (psc_sel),
    .evt_out (evt_div)
  );

  tmr16_core #(.BUS_W(BUS_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .inc       (evt_div),
    .trig_clr  (trig_clr),
    .wide_mode (wide_mode),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .wr_data   (wr_data),
    .ovf_clr   (ovf_clr),
    .count     (count_q),
    .rd_data   (rd_data),
    .ovf_flag  (ovf_flag),
    .cnt_write (cnt_write)
  );

endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
  parameter int BUS_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               run_en,
  input logic               wide_mode,
  input logic               trig_clr,
  input logic               wr_lo,
  input logic               wr_hi,
  input logic               rd_lo,
  input logic               rd_hi,
  input logic               ovf_clr,
  input logic               ovf_flag,
  input logic [BUS_W-1:0]   rd_data,
  input logic [2*BUS_W-1:0] count_i
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (count_i == '0 && !ovf_flag && rd_data == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !wr_lo && !wr_hi && !trig_clr) |=> $stable(count_i));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> ($past(count_i) == '1 && count_i == '0));

  // R8
  trig_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_clr && !wr_lo && !wr_hi) |=> (count_i == '0));

  // R11
  staged_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (wide_mode && wr_hi && !wr_lo && !trig_clr) |=>
      (count_i == $past(count_i) || count_i == $past(count_i) + 1'b1));

  // R13
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_lo && !rd_hi) |=> $stable(rd_data));

endmodule

bind prescaled_timer16 tmr16_chk #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run_en    (run_en),
  .wide_mode (wide_mode),
  .trig_clr  (trig_clr),
  .wr_lo     (wr_lo),
  .wr_hi     (wr_hi),
  .rd_lo     (rd_lo),
  .rd_hi     (rd_hi),
  .ovf_clr   (ovf_clr),
  .ovf_flag  (ovf_flag),
  .rd_data   (rd_data),
  .count_i   (count_q)
);

// File: tb/prescaled_timer16_tb.sv
module prescaled_timer16_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_tick = 0, ext_clk_in = 0, run_en = 0, src_ext = 0, sync_ext = 0;
  logic [1:0] psc_sel = 0;
  logic       wide_mode = 0, trig_clr = 0, wr_lo = 0, wr_hi = 0, rd_lo = 0, rd_hi = 0;
  logic [7:0] wr_data = 0;
  logic       ovf_clr = 0;
  logic [7:0] rd_data;
  logic       ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prescaled_timer16 u_dut (
    .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .ext_clk_in(ext_clk_in),
    .run_en(run_en), .src_ext(src_ext), .sync_ext(sync_ext), .psc_sel(psc_sel),
    .wide_mode(wide_mode), .trig_clr(trig_clr), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .wr_data(wr_data), .ovf_clr(ovf_clr),
    .rd_data(rd_data), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_count(input logic [15:0] s, input int n, input logic [1:0] sel);
    return s + 16'(n >> sel);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(input bit hi, input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    if (hi) wr_hi = 1; else wr_lo = 1;
    @(negedge clk);
    wr_hi = 0; wr_lo = 0;
  endtask

  task automatic rd_byte(input bit hi, output logic [7:0] d);
    @(negedge clk);
    if (hi) rd_hi = 1; else rd_lo = 1;
    @(negedge clk);
    rd_hi = 0; rd_lo = 0;
    d = rd_data;
  endtask

  task automatic write16(input logic [15:0] v);
    wr_byte(1, v[15:8]);
    wr_byte(0, v[7:0]);
  endtask

  task automatic read16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_byte(0, lo);
    rd_byte(1, hi);
    v = {hi, lo};
  endtask

  task automatic tick_n(input int n);
    repeat (n) begin
      @(negedge clk) cyc_tick = 1;
      @(negedge clk) cyc_tick = 0;
      idle(2);
    end
  endtask

  task automatic ext_pulse(input int n);
    repeat (n) begin
      @(negedge clk) ext_clk_in = 1;
      idle(3);
      ext_clk_in = 0;
      idle(3);
    end
  endtask

  task automatic pulse_ovf_clr();
    @(negedge clk) ovf_clr = 1;
    @(negedge clk) ovf_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, st;
    logic [7:0] b;
    logic [1:0] sel;
    int n;
    void'($urandom(32'h5EED_1234));

    idle(3);
    // R1 reset state
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 ovf_flag", int'(ovf_flag), 0);
    @(negedge clk) rst = 0;
    wide_mode = 1;
    read16(v);
    chk("R1 count", int'(v), 0);

    // R2 timer mode, ext pin ignored
    write16(16'h1234);
    run_en = 1;
    fork
      tick_n(5);
      ext_pulse(3);
    join
    run_en = 0;
    read16(v);
    chk("R2 tick count", int'(v), int'(exp_count(16'h1234, 5, 2'd0)));

    // R3 random prescale runs
    for (int i = 0; i < 10; i++) begin
      st  = 16'($urandom);
      sel = 2'($urandom % 4);
      n   = int'($urandom % 40);
      write16(st);
      psc_sel = sel;
      run_en = 1;
      tick_n(n);
      run_en = 0;
      read16(v);
      chk($sformatf("R3 sel=%0d n=%0d", sel, n), int'(v), int'(exp_count(st, n, sel)));
      pulse_ovf_clr();
    end

    // R6 run off: count and prescaler hold
    psc_sel = 2'd1;
    write16(16'h0000);
    run_en = 1; tick_n(1); run_en = 0;
    tick_n(6);
    read16(v);
    chk("R6 hold count", int'(v), 0);
    run_en = 1; tick_n(1); run_en = 0;
    read16(v);
    chk("R6 prescaler kept", int'(v), 1);

    // R12 write clears prescaler
    psc_sel = 2'd2;
    write16(16'h0000);
    run_en = 1; tick_n(3); run_en = 0;
    write16(16'h0100);
    run_en = 1; tick_n(3); run_en = 0;
    read16(v);
    chk("R12 after 3 ticks", int'(v), 16'h0100);
    run_en = 1; tick_n(1); run_en = 0;
    read16(v);
    chk("R12 fourth tick", int'(v), 16'h0101);

    // R4 sync external counting, cyc_tick ignored
    for (int i = 0; i < 3; i++) begin
      sel = 2'($urandom % 4);
      n   = 4 + int'($urandom % 20);
      psc_sel = sel; src_ext = 1; sync_ext = 1;
      write16(16'h0000);
      cyc_tick = 1; run_en = 1;
      ext_pulse(n);
      idle(4);
      run_en = 0; cyc_tick = 0;
      read16(v);
      chk($sformatf("R4 sync sel=%0d n=%0d", sel, n), int'(v), int'(exp_count(16'h0, n, sel)));
    end

    // R5 async external counting
    sel = 2'd1; n = 9;
    psc_sel = sel; sync_ext = 0;
    write16(16'h0000);
    run_en = 1; ext_pulse(n); idle(2); run_en = 0;
    read16(v);
    chk("R5 async count", int'(v), int'(exp_count(16'h0, n, sel)));

    // R4 / R5 latency with low byte strobed every cycle (8-bit mode)
    wide_mode = 0; psc_sel = 0; sync_ext = 1;
    wr_byte(0, 8'h00); wr_byte(1, 8'h00);
    run_en = 1; idle(4);
    @(negedge clk) rd_lo = 1;
    idle(2);
    @(negedge clk) ext_clk_in = 1;
    idle(2);
    chk("R4 sync latency early", int'(rd_data), 0);
    idle(1);
    chk("R4 sync latency at 3rd", int'(rd_data), 0);
    idle(1);
    chk("R4 sync latency visible", int'(rd_data), 1);
    idle(5);
    chk("R4 held high once", int'(rd_data), 1);
    ext_clk_in = 0; idle(5);
    sync_ext = 0; idle(2);
    @(negedge clk) ext_clk_in = 1;
    idle(1);
    chk("R5 async latency early", int'(rd_data), 1);
    idle(1);
    chk("R5 async latency visible", int'(rd_data), 2);
    @(negedge clk) rd_lo = 0; ext_clk_in = 0; run_en = 0;
    src_ext = 0;

    // R13 registered read data
    wr_byte(0, 8'h5A);
    @(negedge clk) rd_lo = 1;
    #1 chk("R13 no change before edge", int'(rd_data), 2);
    @(negedge clk) rd_lo = 0;
    chk("R13 after edge", int'(rd_data), 16'h5A);

    // R9 8-bit mode direct bytes
    wr_byte(1, 8'h12);
    rd_byte(1, b);
    chk("R9 live high", int'(b), 16'h12);
    wr_byte(0, 8'h34);
    rd_byte(0, b);
    chk("R9 live low", int'(b), 16'h34);

    // R10 wide read snapshot
    wide_mode = 1; psc_sel = 0;
    write16(16'h12FF);
    rd_byte(0, b);
    chk("R10 low", int'(b), 16'hFF);
    run_en = 1; tick_n(1); run_en = 0;
    rd_byte(1, b);
    chk("R10 buffered high", int'(b), 16'h12);
    read16(v);
    chk("R10 live after", int'(v), 16'h1300);

    // R11 wide staged write
    wr_byte(1, 8'h77);
    read16(v);
    chk("R11 staged no change", int'(v), 16'h1300);
    wr_byte(1, 8'h77);
    wr_byte(0, 8'h88);
    read16(v);
    chk("R11 commit", int'(v), 16'h7788);

    // R7 overflow
    write16(16'hFFFE);
    run_en = 1; tick_n(1); run_en = 0;
    chk("R7 no flag before wrap", int'(ovf_flag), 0);
    run_en = 1; tick_n(1); run_en = 0;
    chk("R7 flag on wrap", int'(ovf_flag), 1);
    read16(v);
    chk("R7 wrapped count", int'(v), 0);
    run_en = 1; tick_n(2); run_en = 0;
    chk("R7 sticky", int'(ovf_flag), 1);
    pulse_ovf_clr();
    chk("R7 cleared", int'(ovf_flag), 0);
    write16(16'hFFFF);
    run_en = 1;
    @(negedge clk) cyc_tick = 1; ovf_clr = 1;
    @(negedge clk) cyc_tick = 0; ovf_clr = 0;
    run_en = 0;
    chk("R7 set wins over clear", int'(ovf_flag), 1);
    pulse_ovf_clr();

    // R8 trigger clear and write priority
    write16(16'h5555);
    @(negedge clk) trig_clr = 1;
    @(negedge clk) trig_clr = 0;
    read16(v);
    chk("R8 trigger clears", int'(v), 0);
    wr_byte(1, 8'hAB);
    @(negedge clk) wr_data = 8'hCD; wr_lo = 1; trig_clr = 1;
    @(negedge clk) wr_lo = 0; trig_clr = 0;
    read16(v);
    chk("R8 write beats trigger", int'(v), 16'hABCD);
    write16(16'h0010);
    run_en = 1;
    @(negedge clk) cyc_tick = 1; trig_clr = 1;
    @(negedge clk) cyc_tick = 0; trig_clr = 0;
    run_en = 0;
    read16(v);
    chk("R8 trigger beats increment", int'(v), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule